// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address presented to a synchronous burst memory array. On a clock edge where the chip is selected and either of two start strobes is high, it captures an external base address. It then serves that address as the first beat of a burst. Every later edge with the advance input high moves the low address bits to the next beat. The upper bits keep the captured value for the whole burst.

The low bits follow one of two orders, chosen by a burst-order input that is sampled together with the start strobe. Linear order adds the beat count to the starting offset, modulo four. Interleaved order XORs the beat count into the starting offset. All inputs are sampled on the rising clock edge, and the address output comes straight from registers.

Bursting is optional. A new base address can be captured on every cycle without a penalty. The two strobes behave differently when the chip is deselected. The primary strobe is then ignored. The secondary strobe then ends the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `arr_addr` is 0 and `burst_busy` is 0.
- R2: On an edge where the chip is selected (`chip_sel`=1 and `chip_sel_n`=0) and `strobe_pri` or `strobe_sec` is 1, `arr_addr` equals the `ext_addr` sampled at that edge, and `burst_busy` is 1 from the following cycle.
- R3: During a burst, the upper `AW-2` bits of `arr_addr` keep the captured base value. Only bits [1:0] change.
- R4: During a burst, an edge with `advance`=1 and no start moves the burst to the next beat. An edge with `advance`=0 holds `arr_addr`. The beat count wraps after four beats.
- R5: When `lin_order`=1 at the start edge, bits [1:0] on beat k equal (start offset + k) mod 4.
- R6: When `lin_order`=0 at the start edge, bits [1:0] on beat k equal start offset XOR k. Interleaved is the tie-low default. Changes on `lin_order` during a burst have no effect.
- R7: A start on consecutive edges captures each new address with no idle cycle between them.
- R8: When the chip is deselected, `strobe_pri` is ignored. Address and busy state change only as `advance` and `strobe_sec` dictate.
- R9: A start has priority over `advance` on the same edge. The burst restarts at beat 0 at the new address.
- R10: `strobe_sec`=1 while the chip is deselected clears `burst_busy` and holds `arr_addr`. While idle, `advance` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | AW | External base address |
| strobe_pri | input | 1 | Primary start strobe, honoured only when selected |
| strobe_sec | input | 1 | Secondary start strobe; ends the burst when deselected |
| advance | input | 1 | Step to the next beat |
| chip_sel | input | 1 | Active-high chip select |
| chip_sel_n | input | 1 | Active-low chip select |
| lin_order | input | 1 | 1 = linear, 0 = interleaved burst order |
| arr_addr | output | AW | Current array word address |
| burst_busy | output | 1 | A burst is in progress |

## Verification
A start strobe and the advance input can fall on the same edge. The bench provokes this by raising both in the middle of a burst that is already stepping. It then requires beat 0 of the new base on the next cycle, not a step of the old burst.

A deselected primary strobe can also coincide with advance and with the secondary strobe. Those edges are judged at the ports: the address must be unchanged, and the busy flag must take the expected value.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2,
    CMD_STOP = 2'd3
  } bag_cmd_e;
endpackage

// File: rtl/bag_cmd_decode.sv
module bag_cmd_decode
  import bag_pkg::*;
(
  input  logic     strobe_pri,
  input  logic     strobe_sec,
  input  logic     advance,
  input  logic     chip_sel,
  input  logic     chip_sel_n,
  input  logic     busy,
  output bag_cmd_e cmd
);
  logic chip_on;
  logic start;

  always_comb begin
    chip_on = chip_sel & ~chip_sel_n;
    start   = chip_on & (strobe_pri | strobe_sec);
    if (start)                      cmd = CMD_LOAD;
    else if (strobe_sec & ~chip_on) cmd = CMD_STOP;
    else if (advance & busy)        cmd = CMD_STEP;
    else                            cmd = CMD_HOLD;
  end
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_off,
  input  logic [CNT_W-1:0] beat,
  input  burst_order_e     order,
  output logic [CNT_W-1:0] offset
);
  logic [CNT_W-1:0] lin_off;
  logic [CNT_W-1:0] ilv_off;

  assign lin_off = start_off + beat;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_off[b] = start_off[b] ^ beat[b];
  end

  always_comb begin
    offset = (order == ORD_LINEAR) ? lin_off : ilv_off;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW    = 20,
  parameter int CNT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_pri,
  input  logic          strobe_sec,
  input  logic          advance,
  input  logic          chip_sel,
  input  logic          chip_sel_n,
  input  logic          lin_order,
  output logic [AW-1:0] arr_addr,
  output logic          burst_busy
);
  localparam int HI_W = AW - CNT_W;

  bag_cmd_e         cmd;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    base_d;
  burst_order_e     order_q;
  burst_order_e     order_d;
  logic             busy_q;
  logic             busy_d;
  logic             load_en;
  logic             busy_en;
  logic [CNT_W-1:0] beat;
  logic [CNT_W-1:0] offset;

  bag_cmd_decode u_dec (
    .strobe_pri (strobe_pri),
    .strobe_sec (strobe_sec),
    .advance    (advance),
    .chip_sel   (chip_sel),
    .chip_sel_n (chip_sel_n),
    .busy       (busy_q),
    .cmd        (cmd)
  );

  bag_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd == CMD_LOAD),
    .inc   (cmd == CMD_STEP),
    .cnt   (beat)
  );

  // Next-state for captured base, order and busy flag.
  always_comb begin
    load_en = (cmd == CMD_LOAD);
    busy_en = (cmd == CMD_LOAD) || (cmd == CMD_STOP);
    base_d  = ext_addr;
    order_d = lin_order ? ORD_LINEAR : ORD_INTLV;
    busy_d  = (cmd == CMD_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTLV;
    end else if (load_en) begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  bag_order_map #(.CNT_W(CNT_W)) u_map (
    .start_off (base_q[CNT_W-1:0]),
    .beat      (beat),
    .order     (order_q),
    .offset    (offset)
  );

  assign arr_addr   = {base_q[AW-1:CNT_W], offset};
  assign burst_busy = busy_q;

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[AW-1:CNT_W];
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW    = 20,
  parameter int CNT_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          strobe_pri,
  input logic          strobe_sec,
  input logic          advance,
  input logic          chip_sel,
  input logic          chip_sel_n,
  input logic [AW-1:0] arr_addr,
  input logic          burst_busy,
  input logic          order_lin_q
);
  logic sel_on;
  logic start;
  assign sel_on = chip_sel & ~chip_sel_n;
  assign start  = sel_on & (strobe_pri | strobe_sec);

  // R2
  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (arr_addr == $past(ext_addr)) && burst_busy);

  // R9
  a_r9_start_beats_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (start && advance) |=> arr_addr == $past(ext_addr));

  // R3
  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(arr_addr[AW-1:CNT_W]));

  // R4
  a_r4_hold_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !advance) |=> $stable(arr_addr));

  // R5
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(strobe_sec && !sel_on) && advance && burst_busy && order_lin_q)
      |=> arr_addr[CNT_W-1:0] == CNT_W'($past(arr_addr[CNT_W-1:0]) + 1'b1));

  // R8
  a_r8_pri_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_on && strobe_pri && !strobe_sec && !advance)
      |=> $stable(arr_addr) && $stable(burst_busy));

  // R10
  a_r10_sec_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_on && strobe_sec) |=> !burst_busy && $stable(arr_addr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_addr    (ext_addr),
  .strobe_pri  (strobe_pri),
  .strobe_sec  (strobe_sec),
  .advance     (advance),
  .chip_sel    (chip_sel),
  .chip_sel_n  (chip_sel_n),
  .arr_addr    (arr_addr),
  .burst_busy  (burst_busy),
  .order_lin_q (order_q == bag_pkg::ORD_LINEAR)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int  AW      = 20;
  localparam time CLK_PER = 10ns;
  localparam int  WD_MAX  = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_pri, strobe_sec, advance, chip_sel, chip_sel_n, lin_order;
  logic [AW-1:0] arr_addr;
  logic          burst_busy;

  int tests  = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PER/2) clk = ~clk;

  burst_addr_gen #(.AW(AW), .CNT_W(2)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .strobe_pri(strobe_pri), .strobe_sec(strobe_sec), .advance(advance),
    .chip_sel(chip_sel), .chip_sel_n(chip_sel_n), .lin_order(lin_order),
    .arr_addr(arr_addr), .burst_busy(burst_busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_MAX) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, bit lin, int k);
    logic [1:0] kk;
    kk = 2'(k);
    return {b[AW-1:2], lin ? 2'(b[1:0] + kk) : (b[1:0] ^ kk)};
  endfunction

  task automatic cyc(bit p, bit s, bit adv, bit sel_on, bit lin, logic [AW-1:0] a);
    strobe_pri = p; strobe_sec = s; advance = adv;
    chip_sel = sel_on; chip_sel_n = ~sel_on; lin_order = lin; ext_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [AW-1:0] ea, bit eb);
    tests = tests + 1;
    if (arr_addr !== ea || burst_busy !== eb) begin
      fails = fails + 1;
      $display("FAIL %s: addr=%h busy=%b expected addr=%h busy=%b",
               req, arr_addr, burst_busy, ea, eb);
    end
  endtask

  initial begin
    logic [AW-1:0] base, prev;
    rst_n = 1'b0;
    strobe_pri = 0; strobe_sec = 0; advance = 0;
    chip_sel = 0; chip_sel_n = 1; lin_order = 0; ext_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0, 1'b0);

    // Sweep: both orders, every start offset, two upper patterns, beats to wrap.
    for (int ord = 0; ord < 2; ord++) begin
      for (int st = 0; st < 4; st++) begin
        for (int up = 0; up < 2; up++) begin
          base = {(up == 0) ? 18'h3FFFF : 18'h12345, 2'(st)};
          cyc(st[0], ~st[0], 0, 1, ord[0], base);
          check("R2 load", base, 1'b1);
          for (int k = 1; k <= 5; k++) begin
            if (k == 2) begin
              cyc(0, 0, 0, 1, ~ord[0], ~base);
              check("R4 hold no advance", expect_addr(base, ord[0], 1), 1'b1);
            end
            cyc(0, 0, 1, 1, ~ord[0], ~base);
            if (ord == 1) check("R5 linear beat/R3", expect_addr(base, 1, k), 1'b1);
            else          check("R6 interleaved beat/R3", expect_addr(base, 0, k), 1'b1);
          end
        end
      end
    end

    // R9: start with advance mid-burst restarts at beat 0.
    cyc(1, 0, 0, 1, 1, 20'h00102);
    cyc(0, 0, 1, 1, 1, '0);
    check("R5 step before restart", 20'h00103, 1'b1);
    cyc(1, 0, 1, 1, 0, 20'hABCD1);
    check("R9 start over advance", 20'hABCD1, 1'b1);
    cyc(0, 0, 1, 1, 1, '0);
    check("R9 new burst order interleaved", 20'hABCD0, 1'b1);

    // R7: back-to-back loads.
    for (int i = 0; i < 4; i++) begin
      base = 20'h40000 + 20'(i * 37);
      cyc(i[0], ~i[0], 1, 1, 1, base);
      check("R7 back-to-back load", base, 1'b1);
    end

    // R8: deselected primary strobe ignored.
    prev = arr_addr;
    cyc(1, 0, 0, 0, 1, 20'h77777);
    check("R8 pri ignored when deselected", prev, 1'b1);
    cyc(1, 0, 1, 0, 1, 20'h77777);
    check("R8 pri ignored, advance still steps", expect_addr(base, 1, 1), 1'b1);

    // R10: secondary strobe when deselected ends burst; idle advance ignored.
    prev = arr_addr;
    cyc(1, 1, 1, 0, 0, 20'h55555);
    check("R10 sec stops burst", prev, 1'b0);
    cyc(0, 0, 1, 1, 0, 20'h55555);
    check("R10 advance ignored when idle", prev, 1'b0);
    cyc(0, 0, 1, 1, 0, 20'h55555);
    check("R10 still idle", prev, 1'b0);
    cyc(0, 1, 0, 1, 0, 20'h55556);
    check("R2 sec strobe restarts", 20'h55556, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule